// File: doc/BRIEF.md
# Quad SPI Execute-in-Place Read Engine

This block turns single-beat reads from a simple memory-mapped bus into serial flash read transactions, so that code can run straight out of an external SPI flash. A requester holds `req_i` with a byte address until `ready_o` pulses. The engine then returns a 32-bit word assembled from four consecutive flash bytes.

Three static configuration inputs select how each read goes out on the wire:
- The address width, 24 or 32 bits.
- The lane arrangement: single line throughout, quad data only, or quad address and data.
- The number of dummy clocks between the address and the data.

The engine picks the read opcode from the lane arrangement and the address width together. It runs the SPI clock in mode 0 and owns the chip select and four data lines with per-line output enables.

The safest setting is 24-bit addressing, the single-line mode and 8 dummy clocks. The quad modes need a flash whose quad-enable bit has already been set by other means. The opcodes are parameters, so a part with different command values can be served without editing the logic.

Top module: `qspi_xip_reader`

## Requirements
- R1: The opcode depends on lane code and address width. `cfg_lane_i` 0 is 1-1-1 (0x0B for 24-bit, 0x0C for 32-bit), 1 is 1-1-4 (0x6B / 0x6C) and 2 is 1-4-4 (0xEB / 0xEC). Code 3 behaves as 1-1-1. All six opcodes are overridable parameters.
- R2: The opcode goes out MSB first on IO0, one bit per SCK period.
  - In 1-1-1 and 1-1-4 the address follows MSB first on IO0, as 24 bits (the low 24 of `addr_i`, the upper 8 ignored) or as 32 bits.
  - Driven line values change only at a falling SCK edge or when chip select goes low.
- R3: In 1-4-4 the address goes out as nibbles, MSB first, with IO3 carrying the most significant bit of each nibble. It takes 6 clocks (24-bit) or 8 clocks (32-bit), with all four lines driven.
- R4: Exactly `cfg_dummy_i` SCK periods (0 allowed) separate the last address clock from the first data clock.
  - IO0 and IO1 are released during them.
  - IO2 and IO3 are driven high in 1-1-1 and released in the quad modes.
- R5: Data is sampled on the rising SCK edge.
  - In 1-1-1: one bit per clock from IO1, over 32 clocks.
  - In the quad modes: a nibble per clock from IO3..IO0, over 8 clocks, with all lines released.
- R6: The first received byte lands in `rdata_o[7:0]` and the fourth in `rdata_o[31:24]`. Each byte arrives MSB first.
- R7: SCK idles low, stays low while chip select is high, and toggles with a period of exactly `CLK_DIV` system clocks (mode 0).
- R8: Chip select is high in the cycle `ready_o` pulses. It stays high for at least `CLK_DIV` system clocks before the next transaction.
- R9: IO2 and IO3 are driven high while idle and in single-line phases. IO1 is never driven except during the 1-4-4 address phase.
- R10: `ready_o` is a one-cycle pulse. `rdata_o` is valid in that cycle and holds its value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, held until `ready_o` |
| addr_i | input | 32 | Byte address of the read |
| rdata_o | output | 32 | Assembled read word |
| ready_o | output | 1 | One-cycle completion pulse |
| cfg_addr32_i | input | 1 | 1 selects 32-bit addressing, 0 selects 24-bit |
| cfg_lane_i | input | 2 | Lane code: 0 = 1-1-1, 1 = 1-1-4, 2 = 1-4-4, 3 = 1-1-1 |
| cfg_dummy_i | input | 5 | Dummy SCK periods between address and data |
| sck_o | output | 1 | SPI clock |
| cs_no | output | 1 | Chip select, active low |
| io_o | output | 4 | Data line output values |
| io_oe_o | output | 4 | Data line output enables |
| io_i | input | 4 | Data line input values |

## Verification
The hardest moments to reach are the hand-overs of the data lines:
- Where the 1-4-4 address phase releases all four lines.
- Where a zero dummy count makes the flash take over in the very next SCK period.
- Where a 24-bit read crosses the 16 MB boundary, so the four bytes must wrap inside the flash.

The bench carries a behavioural flash model that decodes what the engine sends and drives data only after its own count of clocks. It checks for contention on every cycle. A fixed-seed random sweep covers every lane code, both address widths and dummy counts of 0, 1, 8 and 10. Directed reads at the wrap-around addresses supplement the sweep.

// File: rtl/qspi_xip_pkg.sv
package qspi_xip_pkg;
  typedef enum logic [1:0] {
    LANE_111 = 2'd0,
    LANE_114 = 2'd1,
    LANE_144 = 2'd2,
    LANE_RSV = 2'd3
  } lane_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_GAP   = 3'd5
  } phase_e;

  localparam int unsigned OPC_W  = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned A24_W  = 24;
  localparam int unsigned A32_W  = 32;
endpackage

// File: rtl/qspi_sck_gen.sv
module qspi_sck_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CNT_W   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned HIGH_C  = CLK_DIV / 2;
  localparam int unsigned LOW_C   = CLK_DIV - HIGH_C;
  localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(LOW_C - 1);
  localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign rise_o = en_i && (cnt_q == RISE_AT);
  assign fall_o = en_i && (cnt_q == LAST_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + 1'b1;
      if (rise_o)      sck_o <= 1'b1;
      else if (fall_o) sck_o <= 1'b0;
    end
  end
endmodule

// File: rtl/qspi_cmd_sel.sv
module qspi_cmd_sel
  import qspi_xip_pkg::*;
#(
  parameter logic [7:0] OP_111_A24 = 8'h0B,
  parameter logic [7:0] OP_111_A32 = 8'h0C,
  parameter logic [7:0] OP_114_A24 = 8'h6B,
  parameter logic [7:0] OP_114_A32 = 8'h6C,
  parameter logic [7:0] OP_144_A24 = 8'hEB,
  parameter logic [7:0] OP_144_A32 = 8'hEC,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BEAT_W = 6
) (
  input  logic [1:0]        lane_i,
  input  logic              addr32_i,
  output logic [OPC_W-1:0]  opcode_o,
  output logic              quad_addr_o,
  output logic              quad_data_o,
  output logic [BEAT_W-1:0] addr_beats_o,
  output logic [BEAT_W-1:0] data_beats_o
);
  localparam int unsigned ABITS = 0;

  always_comb begin
    quad_addr_o = 1'b0;
    quad_data_o = 1'b0;
    unique case (lane_i)
      LANE_114: begin
        opcode_o    = addr32_i ? OP_114_A32 : OP_114_A24;
        quad_data_o = 1'b1;
      end
      LANE_144: begin
        opcode_o    = addr32_i ? OP_144_A32 : OP_144_A24;
        quad_addr_o = 1'b1;
        quad_data_o = 1'b1;
      end
      default: opcode_o = addr32_i ? OP_111_A32 : OP_111_A24;
    endcase
  end

  always_comb begin
    logic [BEAT_W-1:0] abits;
    abits        = addr32_i ? BEAT_W'(A32_W + ABITS) : BEAT_W'(A24_W + ABITS);
    addr_beats_o = quad_addr_o ? (abits >> 2) : abits;
    data_beats_o = quad_data_o ? BEAT_W'(DATA_W / NIB_W) : BEAT_W'(DATA_W);
  end
endmodule

// File: rtl/qspi_seq_core.sv
module qspi_seq_core
  import qspi_xip_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned DUMMY_W = 5,
  parameter int unsigned BEAT_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [A32_W-1:0]   addr_i,
  input  logic               cfg_addr32_i,
  input  logic [1:0]         cfg_lane_i,
  input  logic [DUMMY_W-1:0] cfg_dummy_i,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic               quad_addr_i,
  input  logic               quad_data_i,
  input  logic [BEAT_W-1:0]  addr_beats_i,
  input  logic [BEAT_W-1:0]  data_beats_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic [3:0]         io_i,
  output logic               sck_en_o,
  output logic [1:0]         lane_q_o,
  output logic               addr32_q_o,
  output logic               cs_no,
  output logic [3:0]         io_o,
  output logic [3:0]         io_oe_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               ready_o
);
  localparam int unsigned NBYTES = DATA_W / 8;
  localparam int unsigned GAP_W  = $clog2(CLK_DIV + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CLK_DIV - 1);

  phase_e              phase_q;
  logic [BEAT_W-1:0]   bcnt_q;
  logic [GAP_W-1:0]    gap_q;
  logic [A32_W-1:0]    tx_q;
  logic [DATA_W-1:0]   rx_q;
  logic [DATA_W-1:0]   rx_swap;
  logic [DUMMY_W-1:0]  dummy_q;
  logic [1:0]          lane_q;
  logic                addr32_q;
  logic                active;
  logic [BEAT_W-1:0]   dummy_last;

  assign active     = (phase_q == PH_CMD) || (phase_q == PH_ADDR) ||
                      (phase_q == PH_DUMMY) || (phase_q == PH_DATA);
  assign sck_en_o   = active;
  assign cs_no      = !active;
  assign lane_q_o   = lane_q;
  assign addr32_q_o = addr32_q;
  assign dummy_last = BEAT_W'(dummy_q) - BEAT_W'(1);

  // first byte on the wire becomes the least significant byte
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign rx_swap[8*b +: 8] = rx_q[8*(NBYTES-1-b) +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      bcnt_q   <= '0;
      gap_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      dummy_q  <= '0;
      lane_q   <= LANE_111;
      addr32_q <= 1'b0;
      rdata_o  <= '0;
      ready_o  <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      if (rise_i && phase_q == PH_DATA)
        rx_q <= quad_data_i ? {rx_q[DATA_W-5:0], io_i} : {rx_q[DATA_W-2:0], io_i[1]};
      unique case (phase_q)
        PH_IDLE: if (req_i) begin
          phase_q  <= PH_CMD;
          bcnt_q   <= '0;
          lane_q   <= cfg_lane_i;
          addr32_q <= cfg_addr32_i;
          dummy_q  <= cfg_dummy_i;
          tx_q     <= cfg_addr32_i ? addr_i : {addr_i[A24_W-1:0], 8'h00};
        end
        PH_CMD: if (fall_i) begin
          if (bcnt_q == BEAT_W'(OPC_W - 1)) begin
            phase_q <= PH_ADDR;
            bcnt_q  <= '0;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        PH_ADDR: if (fall_i) begin
          tx_q <= quad_addr_i ? {tx_q[A32_W-5:0], 4'h0} : {tx_q[A32_W-2:0], 1'b0};
          if (bcnt_q == addr_beats_i - BEAT_W'(1)) begin
            phase_q <= (dummy_q == '0) ? PH_DATA : PH_DUMMY;
            bcnt_q  <= '0;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        PH_DUMMY: if (fall_i) begin
          if (bcnt_q == dummy_last) begin
            phase_q <= PH_DATA;
            bcnt_q  <= '0;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        PH_DATA: if (fall_i) begin
          if (bcnt_q == data_beats_i - BEAT_W'(1)) begin
            phase_q <= PH_GAP;
            bcnt_q  <= '0;
            gap_q   <= '0;
            rdata_o <= rx_swap;
            ready_o <= 1'b1;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        PH_GAP: begin
          if (gap_q == GAP_LAST) phase_q <= PH_IDLE;
          else                   gap_q   <= gap_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // line drive per phase; IO2/IO3 parked high whenever not in a quad phase
  always_comb begin
    io_o    = 4'b1100;
    io_oe_o = 4'b1100;
    unique case (phase_q)
      PH_CMD: begin
        io_o[0]    = opcode_i[3'd7 - bcnt_q[2:0]];
        io_oe_o[0] = 1'b1;
      end
      PH_ADDR: begin
        if (quad_addr_i) begin
          io_o    = tx_q[A32_W-1 -: 4];
          io_oe_o = 4'b1111;
        end else begin
          io_o[0]    = tx_q[A32_W-1];
          io_oe_o[0] = 1'b1;
        end
      end
      PH_DUMMY, PH_DATA: begin
        if (quad_data_i) begin
          io_o    = 4'b0000;
          io_oe_o = 4'b0000;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader
  import qspi_xip_pkg::*;
#(
  parameter int unsigned CLK_DIV    = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DUMMY_W    = 5,
  parameter logic [7:0]  OP_111_A24 = 8'h0B,
  parameter logic [7:0]  OP_111_A32 = 8'h0C,
  parameter logic [7:0]  OP_114_A24 = 8'h6B,
  parameter logic [7:0]  OP_114_A32 = 8'h6C,
  parameter logic [7:0]  OP_144_A24 = 8'hEB,
  parameter logic [7:0]  OP_144_A32 = 8'hEC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [31:0]        addr_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               ready_o,
  input  logic               cfg_addr32_i,
  input  logic [1:0]         cfg_lane_i,
  input  logic [DUMMY_W-1:0] cfg_dummy_i,
  output logic               sck_o,
  output logic               cs_no,
  output logic [3:0]         io_o,
  output logic [3:0]         io_oe_o,
  input  logic [3:0]         io_i
);
  localparam int unsigned BW_D   = $clog2(DATA_W + 1);
  localparam int unsigned BW_M   = (BW_D > DUMMY_W) ? BW_D : DUMMY_W;
  localparam int unsigned BEAT_W = (BW_M > 6) ? BW_M : 6;

  logic              sck_en, rise, fall;
  logic [1:0]        lane_q;
  logic              addr32_q;
  logic [OPC_W-1:0]  opcode;
  logic              quad_addr, quad_data;
  logic [BEAT_W-1:0] addr_beats, data_beats;

  qspi_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sck_en),
    .sck_o  (sck_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  qspi_cmd_sel #(
    .OP_111_A24 (OP_111_A24), .OP_111_A32 (OP_111_A32),
    .OP_114_A24 (OP_114_A24), .OP_114_A32 (OP_114_A32),
    .OP_144_A24 (OP_144_A24), .OP_144_A32 (OP_144_A32),
    .DATA_W     (DATA_W),     .BEAT_W     (BEAT_W)
  ) u_cmd (
    .lane_i       (lane_q),
    .addr32_i     (addr32_q),
    .opcode_o     (opcode),
    .quad_addr_o  (quad_addr),
    .quad_data_o  (quad_data),
    .addr_beats_o (addr_beats),
    .data_beats_o (data_beats)
  );

  qspi_seq_core #(
    .CLK_DIV (CLK_DIV), .DATA_W (DATA_W), .DUMMY_W (DUMMY_W), .BEAT_W (BEAT_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .addr_i       (addr_i),
    .cfg_addr32_i (cfg_addr32_i),
    .cfg_lane_i   (cfg_lane_i),
    .cfg_dummy_i  (cfg_dummy_i),
    .opcode_i     (opcode),
    .quad_addr_i  (quad_addr),
    .quad_data_i  (quad_data),
    .addr_beats_i (addr_beats),
    .data_beats_i (data_beats),
    .rise_i       (rise),
    .fall_i       (fall),
    .io_i         (io_i),
    .sck_en_o     (sck_en),
    .lane_q_o     (lane_q),
    .addr32_q_o   (addr32_q),
    .cs_no        (cs_no),
    .io_o         (io_o),
    .io_oe_o      (io_oe_o),
    .rdata_o      (rdata_o),
    .ready_o      (ready_o)
  );
endmodule

// File: rtl/qspi_xip_reader_chk.sv
module qspi_xip_reader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_o,
  input logic [1:0] cfg_lane_i,
  input logic       sck_o,
  input logic       cs_no,
  input logic [3:0] io_o,
  input logic [3:0] io_oe_o
);
  assert_sck_idle_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  assert_ready_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  assert_cs_high_on_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cs_no);

  assert_cs_release_with_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> ready_o);

  assert_idle_lines_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (io_oe_o == 4'b1100 && io_o[3:2] == 2'b11));

  assert_io1_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_lane_i != 2'd2) |-> !io_oe_o[1]);

  assert_io_change_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no) && !$fell(sck_o)) |-> ($stable(io_o) && $stable(io_oe_o)));
endmodule

bind qspi_xip_reader qspi_xip_reader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .cfg_lane_i (cfg_lane_i),
  .sck_o      (sck_o),
  .cs_no      (cs_no),
  .io_o       (io_o),
  .io_oe_o    (io_oe_o)
);

// File: tb/qspi_xip_reader_test.sv
`timescale 1ns/1ps
module qspi_xip_reader_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [31:0] addr;
  logic [31:0] rdata;
  logic        ready;
  logic        a32;
  logic [1:0]  lane;
  logic [4:0]  dmy;
  logic        sck, cs_n;
  logic [3:0]  io_out, io_oe, io_in;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  qspi_xip_reader #(.CLK_DIV(DIV)) uut (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .addr_i (addr),
    .rdata_o (rdata), .ready_o (ready),
    .cfg_addr32_i (a32), .cfg_lane_i (lane), .cfg_dummy_i (dmy),
    .sck_o (sck), .cs_no (cs_n), .io_o (io_out), .io_oe_o (io_oe), .io_i (io_in)
  );

  function automatic logic [7:0] exp_op(input logic [1:0] l, input logic w32);
    case (l)
      2'd1:    return w32 ? 8'h6C : 8'h6B;
      2'd2:    return w32 ? 8'hEC : 8'hEB;
      default: return w32 ? 8'h0C : 8'h0B;
    endcase
  endfunction

  function automatic int addr_clks(input logic [1:0] l, input logic w32);
    int bits = w32 ? 32 : 24;
    return (l == 2'd2) ? bits / 4 : bits;
  endfunction

  function automatic bit quad_rx(input logic [1:0] l);
    return (l == 2'd1) || (l == 2'd2);
  endfunction

  function automatic logic [31:0] amask(input logic w32);
    return w32 ? 32'hFFFF_FFFF : 32'h00FF_FFFF;
  endfunction

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ (a[23:16] * 8'd5) ^ (a[31:24] * 8'd7) ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a, input logic w32);
    logic [31:0] m = amask(w32);
    return {mem_byte((a + 3) & m), mem_byte((a + 2) & m),
            mem_byte((a + 1) & m), mem_byte(a & m)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // behavioural flash model
  logic [3:0]  f_oe = 4'b0, f_val = 4'b0;
  logic [7:0]  f_op;
  logic [31:0] f_addr;
  int rc = 0, cyc = 0, last_rise = 0, cs_rise_cyc = -100;
  logic sck_prev = 1'b0, cs_prev = 1'b1;
  logic [7:0]  cap_op;
  logic [31:0] cap_addr;
  int cap_rc;
  int per_err = 0, dum_err = 0, cont_err = 0, gap_err = 0;

  assign io_in = (f_oe & f_val) | (~f_oe & io_oe & io_out);

  always @(negedge clk) begin
    int ab, dm, pre, j, k;
    logic [7:0] b;
    ab  = addr_clks(lane, a32);
    dm  = int'(dmy);
    pre = 8 + ab + dm;
    if (cs_n) begin
      if (!cs_prev) begin
        cap_op = f_op; cap_addr = f_addr; cap_rc = rc; cs_rise_cyc = cyc;
      end
      rc = 0; f_oe = 4'b0; f_op = 8'h0; f_addr = 32'h0;
    end else begin
      if (cs_prev && (cyc - cs_rise_cyc) < DIV) gap_err++;
      if (sck && !sck_prev) begin
        if (rc > 0 && (cyc - last_rise) != DIV) per_err++;
        last_rise = cyc;
        if (rc < 8) f_op = {f_op[6:0], io_out[0]};
        else if (rc < 8 + ab)
          f_addr = (lane == 2'd2) ? {f_addr[27:0], io_out} : {f_addr[30:0], io_out[0]};
        else if (rc < pre) begin
          if (io_oe != (quad_rx(lane) ? 4'b0000 : 4'b1100)) dum_err++;
        end
        rc++;
      end
      if (!sck && sck_prev && rc >= pre) begin
        j = rc - pre;
        if (quad_rx(lane) && j < 8) begin
          k = j / 2;
          b = mem_byte((f_addr + k) & amask(a32));
          f_val = (j % 2 == 0) ? b[7:4] : b[3:0];
          f_oe  = 4'b1111;
        end else if (!quad_rx(lane) && j < 32) begin
          k = j / 8;
          b = mem_byte((f_addr + k) & amask(a32));
          f_val = {2'b00, b[7 - (j % 8)], 1'b0};
          f_oe  = 4'b0010;
        end else begin
          f_oe = 4'b0;
        end
      end
    end
    if ((f_oe & io_oe) != 4'b0) cont_err++;
    sck_prev = sck;
    cs_prev  = cs_n;
    cyc++;
  end

  task automatic do_read(input logic [31:0] a);
    int n = 0;
    logic [31:0] got, exp_a;
    int exp_rc;
    @(negedge clk);
    req = 1'b1; addr = a;
    while (!ready && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, "R10 completion", 32'(n), 32'd5000);
    got = rdata; req = 1'b0;
    @(negedge clk);
    chk(!ready, "R10 ready single cycle", {31'b0, ready}, 32'd0);
    chk(cap_op == exp_op(lane, a32), "R1 opcode", {24'b0, cap_op}, {24'b0, exp_op(lane, a32)});
    exp_a = a & amask(a32);
    chk(cap_addr == exp_a, (lane == 2'd2) ? "R3 quad address" : "R2 serial address", cap_addr, exp_a);
    exp_rc = 8 + addr_clks(lane, a32) + int'(dmy) + (quad_rx(lane) ? 8 : 32);
    chk(cap_rc == exp_rc, "R4 R5 clock count", 32'(cap_rc), 32'(exp_rc));
    chk(got == exp_word(a, a32), "R6 read word", got, exp_word(a, a32));
    repeat (3) @(negedge clk);
    chk(rdata == got, "R10 rdata held", rdata, got);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] dlist [4];
    int seed;
    seed = int'($urandom(32'd2024));
    dlist[0] = 5'd8; dlist[1] = 5'd10; dlist[2] = 5'd0; dlist[3] = 5'd1;
    rst_n = 1'b0; req = 1'b0; addr = '0;
    a32 = 1'b0; lane = 2'd0; dmy = 5'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sck, "R7 reset idle", {30'b0, cs_n, sck}, 32'd2);
    chk(!ready, "R10 reset ready", {31'b0, ready}, 32'd0);
    chk(io_oe == 4'b1100 && io_out[3:2] == 2'b11, "R9 reset lines",
        {24'b0, io_oe, io_out}, 32'hC0);

    // default safe setting and wrap corners
    do_read(32'h0000_0000);
    do_read(32'h00FF_FFFE);
    do_read(32'hAB12_3456);
    a32 = 1'b1;
    do_read(32'hFFFF_FFFE);
    do_read(32'hAB12_3456);
    lane = 2'd2; dmy = 5'd0;
    do_read(32'h00FF_FFFF);
    a32 = 1'b0;
    do_read(32'hFFFF_FFFD);

    for (int l = 0; l < 4; l++) begin
      for (int w = 0; w < 2; w++) begin
        for (int d = 0; d < 4; d++) begin
          lane = 2'(l); a32 = w[0]; dmy = dlist[d];
          for (int r = 0; r < 2; r++) do_read($urandom);
        end
      end
    end

    chk(per_err == 0, "R7 sck period", 32'(per_err), 32'd0);
    chk(dum_err == 0, "R4 dummy line release", 32'(dum_err), 32'd0);
    chk(cont_err == 0, "R9 R5 no line contention", 32'(cont_err), 32'd0);
    chk(gap_err == 0, "R8 chip select gap", 32'(gap_err), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule